// File: doc/BRIEF.md
# Clock Source Control Unit

This unit holds two 8-bit control registers on a simple register bus and turns them into the clocking for a chip. The first register, at address 0, governs the core clock. It enables the main frequency multiplier, picks the multiplier's loop divide ratio, and selects whether the core runs from the crystal or from the multiplied clock. The second register, at address 1, governs the dot clock in the same way. It adds an optional halving of its output, which is on when its control bit is 0.

The analog multiplier loops are outside the unit. Their clocks arrive on two inputs, and the unit reports the loop divide counts it wants them to use. Every change of clock source goes through a glitch-free switch that gates the old clock off on its falling edge before the new clock is gated on. The core clock falls back to the crystal whenever the main multiplier is disabled. A sticky error flag reports a write that turns a multiplier on while also changing its ratio.

Top module: `clkSrcCtrl`

## Requirements
- R1: After reset both registers read 00h, the error flag is 0, both ratio outputs are 1, the core clock follows the crystal, and the dot clock is held low.
- R2: Address 0 selects the core register and address 1 the dot register. In each, bit 7 is the enable, bit 6 is the mode bit and bits 3:0 are the ratio. Bits 5:4 always read as zero.
- R3: mainRatio equals core register bits 3:0 plus 1, and dotRatio equals dot register bits 3:0 plus 1. Both hold their value while no write occurs.
- R4: The core clock follows mulClkIn only while core register bits 7 and 6 are both 1. In every other case it follows the crystal, even when bit 6 is 1.
- R5: When dot register bit 7 is 0, the dot clock is held low. When bit 7 is 1 and bit 6 is 0, the dot clock runs at half the dotClkIn rate. When bits 7 and 6 are both 1, the dot clock equals dotClkIn.
- R6: A write that has bit 7 set and changes bits 3:0 of its target register sets errFlag. Any other write clears it. With no write, the flag keeps its value.
- R7: While halt is high, both registers and errFlag return to their reset values at the next clk edge, and writes are ignored.
- R8: Source changes are glitch-free. No high or low pulse on coreClk or dotClk is shorter than the shorter half period of the two clocks being switched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Forces the registers back to reset values |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register address: 0 core, 1 dot |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed register |
| xtalClk | input | 1 | Crystal clock |
| mulClkIn | input | 1 | Main multiplier output clock |
| dotClkIn | input | 1 | Dot multiplier output clock |
| coreClk | output | 1 | Core clock |
| dotClk | output | 1 | Dot clock |
| mainRatio | output | 5 | Main loop divide count |
| dotRatio | output | 5 | Dot loop divide count |
| errFlag | output | 1 | Sticky ordering error flag |

## Verification
The bench builds the unit with its default parameters: a 4-bit ratio field and two synchronizer stages in each clock switch. It ties the crystal to the 20 ns bus clock and feeds 8 ns and 6 ns multiplier clocks. With these periods, edge counts over a fixed window tell all three core and dot sources apart, as well as the halved dot clock. The 4-bit field makes every ratio up to 16 reachable, so the error rule can be tried with both equal and changed ratios. Minimum pulse widths are recorded over every switch between sources.

// File: rtl/clkSrcPkg.sv
package clkSrcPkg;
  localparam int REG_W   = 8;
  localparam int EN_BIT  = 7;
  localparam int MODE_BIT = 6;

  typedef struct packed {
    logic coreUseMul;
    logic dotRun;
    logic dotBypass;
  } clkStrobes_t;
endpackage

// File: rtl/clkSwitch.sv
module clkSwitch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clkA,
  input  logic clkB,
  input  logic rstN,
  input  logic selB,
  output logic clkOut
);
  logic enA, enB;
  logic [SYNC_STAGES-1:0] syncA, syncB;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(negedge clkA or negedge rstN)
        if (!rstN) syncA <= '1;
        else       syncA <= ~selB & ~enB;
      always_ff @(negedge clkB or negedge rstN)
        if (!rstN) syncB <= '0;
        else       syncB <= selB & ~enA;
    end else begin : gChain
      always_ff @(negedge clkA or negedge rstN)
        if (!rstN) syncA <= '1;
        else       syncA <= {syncA[SYNC_STAGES-2:0], ~selB & ~enB};
      always_ff @(negedge clkB or negedge rstN)
        if (!rstN) syncB <= '0;
        else       syncB <= {syncB[SYNC_STAGES-2:0], selB & ~enA};
    end
  endgenerate

  assign enA = syncA[SYNC_STAGES-1];
  assign enB = syncB[SYNC_STAGES-1];
  assign clkOut = (clkA & enA) | (clkB & enB);
endmodule

// File: rtl/clkRegCtrl.sv
module clkRegCtrl
  import clkSrcPkg::*;
#(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               halt,
  input  logic               wrEn,
  input  logic               regSel,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  output logic [RATIO_W:0]   mainRatio,
  output logic [RATIO_W:0]   dotRatio,
  output logic               errFlag,
  output clkStrobes_t        strobes
);
  localparam int CNT_W = RATIO_W + 1;

  logic mainEn, mainSel, dotEn, dotBypass;
  logic [RATIO_W-1:0] mainDiv, dotDiv, oldDiv;

  assign oldDiv = regSel ? dotDiv : mainDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainEn <= 1'b0; mainSel <= 1'b0; mainDiv <= '0;
      dotEn <= 1'b0; dotBypass <= 1'b0; dotDiv <= '0;
      errFlag <= 1'b0;
    end else if (halt) begin
      mainEn <= 1'b0; mainSel <= 1'b0; mainDiv <= '0;
      dotEn <= 1'b0; dotBypass <= 1'b0; dotDiv <= '0;
      errFlag <= 1'b0;
    end else if (wrEn) begin
      if (regSel) begin
        dotEn     <= wrData[EN_BIT];
        dotBypass <= wrData[MODE_BIT];
        dotDiv    <= wrData[RATIO_W-1:0];
      end else begin
        mainEn  <= wrData[EN_BIT];
        mainSel <= wrData[MODE_BIT];
        mainDiv <= wrData[RATIO_W-1:0];
      end
      errFlag <= wrData[EN_BIT] && (wrData[RATIO_W-1:0] != oldDiv);
    end
  end

  always_comb begin
    rdData = '0;
    if (regSel) begin
      rdData[EN_BIT]        = dotEn;
      rdData[MODE_BIT]      = dotBypass;
      rdData[RATIO_W-1:0]   = dotDiv;
    end else begin
      rdData[EN_BIT]        = mainEn;
      rdData[MODE_BIT]      = mainSel;
      rdData[RATIO_W-1:0]   = mainDiv;
    end
  end

  assign mainRatio = CNT_W'(mainDiv) + CNT_W'(1);
  assign dotRatio  = CNT_W'(dotDiv) + CNT_W'(1);

  assign strobes.coreUseMul = mainEn & mainSel;
  assign strobes.dotRun     = dotEn;
  assign strobes.dotBypass  = dotBypass;
endmodule

// File: rtl/clkDatapath.sv
module clkDatapath
  import clkSrcPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        rstN,
  input  logic        xtalClk,
  input  logic        mulClkIn,
  input  logic        dotClkIn,
  input  clkStrobes_t strobes,
  output logic        coreClk,
  output logic        dotClk
);
  logic dotHalf, dotSel, dotGate;

  always_ff @(posedge dotClkIn or negedge rstN)
    if (!rstN) dotHalf <= 1'b0;
    else       dotHalf <= ~dotHalf;

  clkSwitch #(.SYNC_STAGES(SYNC_STAGES)) uCoreSw (
    .clkA(xtalClk), .clkB(mulClkIn), .rstN(rstN),
    .selB(strobes.coreUseMul), .clkOut(coreClk)
  );

  clkSwitch #(.SYNC_STAGES(SYNC_STAGES)) uDotSw (
    .clkA(dotHalf), .clkB(dotClkIn), .rstN(rstN),
    .selB(strobes.dotBypass), .clkOut(dotSel)
  );

  always_ff @(negedge dotSel or negedge rstN)
    if (!rstN) dotGate <= 1'b0;
    else       dotGate <= strobes.dotRun;

  assign dotClk = dotSel & dotGate;
endmodule

// File: rtl/clkSrcCtrl.sv
module clkSrcCtrl
  import clkSrcPkg::*;
#(
  parameter int RATIO_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halt,
  input  logic             wrEn,
  input  logic             regSel,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             xtalClk,
  input  logic             mulClkIn,
  input  logic             dotClkIn,
  output logic             coreClk,
  output logic             dotClk,
  output logic [RATIO_W:0] mainRatio,
  output logic [RATIO_W:0] dotRatio,
  output logic             errFlag
);
  clkStrobes_t strobes;

  clkRegCtrl #(.RATIO_W(RATIO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .halt(halt), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .mainRatio(mainRatio),
    .dotRatio(dotRatio), .errFlag(errFlag), .strobes(strobes)
  );

  clkDatapath #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .rstN(rstN), .xtalClk(xtalClk), .mulClkIn(mulClkIn),
    .dotClkIn(dotClkIn), .strobes(strobes),
    .coreClk(coreClk), .dotClk(dotClk)
  );
endmodule

// File: rtl/clkSrcCtrlChk.sv
module clkSrcCtrlChk #(
  parameter int RATIO_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             halt,
  input logic             wrEn,
  input logic [7:0]       rdData,
  input logic [RATIO_W:0] mainRatio,
  input logic [RATIO_W:0] dotRatio,
  input logic             errFlag
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[5:4] == 2'b00);  // R2

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !halt) |=> ($stable(mainRatio) && $stable(dotRatio)));  // R3

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !halt) |=> $stable(errFlag));  // R6

  AST_ERR_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(wrEn));  // R6

  AST_HALT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> (mainRatio == 1 && dotRatio == 1 && !errFlag));  // R7
endmodule

bind clkSrcCtrl clkSrcCtrlChk #(.RATIO_W(RATIO_W)) uChk (
  .clk(clk), .rstN(rstN), .halt(halt), .wrEn(wrEn), .rdData(rdData),
  .mainRatio(mainRatio), .dotRatio(dotRatio), .errFlag(errFlag)
);

// File: tb/tb_clkSrcCtrl.sv
`timescale 1ns/1ps
module tb_clkSrcCtrl;
  logic clk = 1'b0, rstN = 1'b0, halt = 1'b0, wrEn = 1'b0, regSel = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic mulClkIn = 1'b0, dotClkIn = 1'b0;
  logic coreClk, dotClk, errFlag;
  logic [4:0] mainRatio, dotRatio;

  always #10 clk = ~clk;
  always #4  mulClkIn = ~mulClkIn;
  always #3  dotClkIn = ~dotClkIn;

  clkSrcCtrl dut (
    .clk(clk), .rstN(rstN), .halt(halt), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .xtalClk(clk), .mulClkIn(mulClkIn),
    .dotClkIn(dotClkIn), .coreClk(coreClk), .dotClk(dotClk),
    .mainRatio(mainRatio), .dotRatio(dotRatio), .errFlag(errFlag)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic       err;
    logic [4:0] mr;
    logic [4:0] dr;
    string      tag;
  } expItem_t;
  expItem_t sbQ[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkRange(string tag, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // monitor: pops expectations and compares against the ports
  always @(posedge clk) begin
    #2;
    if (sbQ.size() > 0) begin
      expItem_t it;
      it = sbQ.pop_front();
      chk({it.tag, " rdData"}, rdData, it.rd);
      chk({it.tag, " errFlag"}, errFlag, it.err);
      chk({it.tag, " mainRatio"}, mainRatio, it.mr);
      chk({it.tag, " dotRatio"}, dotRatio, it.dr);
    end
  end

  task automatic expectRead(logic a, logic [7:0] rd, logic err,
                            logic [4:0] mr, logic [4:0] dr, string tag);
    expItem_t it;
    @(negedge clk);
    regSel = a;
    it.rd = rd; it.err = err; it.mr = mr; it.dr = dr; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic writeReg(logic a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regSel = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  int coreCnt = 0, dotCnt = 0;
  bit countOn = 1'b0;
  always @(posedge coreClk) if (countOn) coreCnt++;
  always @(posedge dotClk)  if (countOn) dotCnt++;

  task automatic measure(int cLo, int cHi, int dLo, int dHi, string tag);
    #200;
    coreCnt = 0; dotCnt = 0; countOn = 1'b1;
    #400;
    countOn = 1'b0;
    chkRange({tag, " coreClk edges"}, coreCnt, cLo, cHi);
    chkRange({tag, " dotClk edges"}, dotCnt, dLo, dHi);
  endtask

  // pulse width recorders for glitch checks
  bit pulseOn = 1'b0;
  realtime coreLast = 0, dotLast = 0, coreMin = 1.0e9, dotMin = 1.0e9;
  bit coreSeen = 1'b0, dotSeen = 1'b0;
  always @(coreClk) if (pulseOn) begin
    if (coreSeen && ($realtime - coreLast) < coreMin) coreMin = $realtime - coreLast;
    coreLast = $realtime; coreSeen = 1'b1;
  end
  always @(dotClk) if (pulseOn) begin
    if (dotSeen && ($realtime - dotLast) < dotMin) dotMin = $realtime - dotLast;
    dotLast = $realtime; dotSeen = 1'b1;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    pulseOn = 1'b1;

    // R1 reset state
    expectRead(1'b0, 8'h00, 1'b0, 5'd1, 5'd1, "R1 core reg");
    expectRead(1'b1, 8'h00, 1'b0, 5'd1, 5'd1, "R1 dot reg");
    measure(19, 21, 0, 0, "R1");

    // R3 ratio, enable off
    writeReg(1'b0, 8'h05);
    expectRead(1'b0, 8'h05, 1'b0, 5'd6, 5'd1, "R3 ratio");
    measure(19, 21, 0, 0, "R4 disabled xtal");

    // R6 ordered enable gives no error
    writeReg(1'b0, 8'h85);
    expectRead(1'b0, 8'h85, 1'b0, 5'd6, 5'd1, "R6 ordered enable");
    measure(19, 21, 0, 0, "R4 enabled not selected");

    writeReg(1'b0, 8'hC5);
    expectRead(1'b0, 8'hC5, 1'b0, 5'd6, 5'd1, "R4 mul select");
    measure(48, 52, 0, 0, "R4 mul");

    // R4 fallback: select set but multiplier off
    writeReg(1'b0, 8'h47);
    expectRead(1'b0, 8'h47, 1'b0, 5'd8, 5'd1, "R4 fallback reg");
    measure(19, 21, 0, 0, "R4 fallback");

    // R6 enable with ratio change
    writeReg(1'b0, 8'h8A);
    expectRead(1'b0, 8'h8A, 1'b1, 5'd11, 5'd1, "R6 set");
    expectRead(1'b0, 8'h8A, 1'b1, 5'd11, 5'd1, "R6 sticky");

    // R2 reserved bits, R6 clear by next write
    writeReg(1'b1, 8'h33);
    expectRead(1'b1, 8'h03, 1'b0, 5'd11, 5'd4, "R2 R6 dot reg");

    writeReg(1'b1, 8'h83);
    expectRead(1'b1, 8'h83, 1'b0, 5'd11, 5'd4, "R5 div reg");
    measure(19, 21, 32, 35, "R5 halved");

    writeReg(1'b1, 8'hC3);
    expectRead(1'b1, 8'hC3, 1'b0, 5'd11, 5'd4, "R5 bypass reg");
    measure(19, 21, 65, 68, "R5 bypass");

    writeReg(1'b0, 8'hC9);
    expectRead(1'b0, 8'hC9, 1'b1, 5'd10, 5'd4, "R6 set again");
    measure(48, 52, 65, 68, "R4 R5 both running");

    // R7 halt clears everything and blocks a write
    @(negedge clk);
    halt = 1'b1; wrEn = 1'b1; regSel = 1'b1; wrData = 8'hC3;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    halt = 1'b0;
    expectRead(1'b0, 8'h00, 1'b0, 5'd1, 5'd1, "R7 core reg");
    expectRead(1'b1, 8'h00, 1'b0, 5'd1, 5'd1, "R7 dot reg");
    measure(19, 21, 0, 0, "R7");
    chk("R7 dotClk low", dotClk, 0);

    // R8 minimum pulse widths over all switches (in ps)
    chkRange("R8 coreClk min pulse", int'(coreMin * 1000.0), 3900, 1000000);
    chkRange("R8 dotClk min pulse", int'(dotMin * 1000.0), 2900, 1000000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule